// File: doc/BRIEF.md
# Interline CCD Drive Timing Generator

This block derives every digital drive and synchronisation signal for a progressive-scan interline CCD from a single master clock. One pixel period spans a fixed number of master-clock ticks, and the horizontal position is counted in whole pixel units. From these counters the block produces the two-phase horizontal shift clocks, the per-pixel reset-gate pulse, and the reference and data sample strobes for correlated double sampling. It also produces the vertical gate controls and the sensor readout pulses that an external driver merges onto the second vertical gate pair. The remaining outputs are line and frame sync, a transfer-blanking flag, an active-pixel flag and the substrate drain pulse that implements the electronic shutter.

Two line-sequencing modes are supported. In full progressive readout, every line shifts the vertical register by one row and both readout pulses fire. In fast readout, each line shifts three rows, fewer lines carry horizontal transfer, the frame is shorter, and only the first readout pulse fires. The shutter is programmed as a line number. Drain pulses are issued in line blanking on each line before that line, so exposure starts there. Mode and shutter settings are sampled only when a frame wraps, so a frame is never cut short.

Top module: `ccd_tg`

## Requirements
- R1: `hsync` is high during the first HD_W pixels of every line. A line lasts LINE_PIX = H_BLANK + H_DUMMY + H_OB_FRONT + H_EFF + H_OB_REAR pixels, each of PIX_TICKS clocks.
- R2: `vsync` is high for the whole of frame line 0. With `fast_mode` = 0 (progressive) a frame is V_TOT_PROG lines long, and with `fast_mode` = 1 (fast) it is V_TOT_FAST lines long.
- R3: Transfer lines are lines 1 to V_ROWS in progressive mode and lines 1 to ceil(V_ROWS/3) in fast mode. `xfer_blank` is low exactly on pixels H_BLANK to LINE_PIX-1 of transfer lines.
- R4: `pix_active` is high only on the H_EFF pixels that start H_DUMMY + H_OB_FRONT pixels into the transfer window. This gives exactly H_EFF*PIX_TICKS active clocks per transfer line and none on other lines.
- R5: In the transfer window, `hclk1` is high for the first PIX_TICKS/2 ticks of each pixel and `hclk2` is its complement. Outside the window they are held at `hclk1`=1 and `hclk2`=0.
- R6: Inside the transfer window, `rst_gate`, `samp_ref` and `samp_data` are each high for one tick per pixel, at sub-ticks RG_POS, SHP_POS and SHD_POS (SHP_POS < SHD_POS). They are low elsewhere.
- R7: On transfer lines, starting at pixel VS_START, the gates {`vg1`,`vg2a`/`vg2b`,`vg3`} step through 110, 010, 011, 001, 101, 100 and then return to 110, holding each step for VS_STEP pixels. This sequence runs once per line in progressive mode and three times in fast mode. At all other times the gates rest at 110, and `vg2a` always equals `vg2b`.
- R8: On line 0, `rd_pulse_a` is high for RD_W pixels starting at pixel RD_POS. `rd_pulse_b` has the same width and starts RD_SKEW pixels later, in progressive mode only. Each readout pulse therefore rises once per frame, or never in the fast-mode case of `rd_pulse_b`, and the second gate pair is high throughout.
- R9: With the shutter enabled, `sub_drain` is high for SUB_W pixels from pixel SUB_POS on every line L with 1 <= L < shutter line. It is never high otherwise, and it always falls inside transfer blanking.
- R10: `fast_mode`, `shutter_en` and `shutter_line` are sampled during reset and at the clock where the frame wraps to line 0. A change at any other time has no effect until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, PIX_TICKS ticks per pixel |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_mode | input | 1 | 0 progressive readout, 1 one-line-in-three fast readout |
| shutter_en | input | 1 | Enables substrate drain pulses |
| shutter_line | input | LINE_W | First exposed line; drain on lines before it |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync |
| xfer_blank | output | 1 | High when no horizontal transfer is running |
| pix_active | output | 1 | High on effective pixels |
| hclk1 | output | 1 | Horizontal shift clock phase 1 |
| hclk2 | output | 1 | Horizontal shift clock phase 2 |
| rst_gate | output | 1 | Output-node reset pulse |
| samp_ref | output | 1 | Reference-level sample strobe |
| samp_data | output | 1 | Data-level sample strobe |
| vg1 | output | 1 | Vertical gate 1 |
| vg2a | output | 1 | Vertical gate 2, half A |
| vg2b | output | 1 | Vertical gate 2, half B |
| vg3 | output | 1 | Vertical gate 3 |
| rd_pulse_a | output | 1 | Sensor readout pulse merged onto gate 2A |
| rd_pulse_b | output | 1 | Sensor readout pulse merged onto gate 2B |
| sub_drain | output | 1 | Substrate drain (shutter) pulse |

## Verification
The main sequencing is tried in three patterns: progressive frames with the shutter off, fast frames with several shutter lines, and a return to progressive with the shutter covering every line. Comparing progressive against fast separates line count, shifts per line, transfer-line count and the presence of the second readout pulse. The shutter settings of none, only line 1 and all lines separate the two ends of the drain-line range. Every input change is made mid-frame, so any change applied before the frame wraps shows up as a mismatch against the reference model in the remainder of that frame.

// File: rtl/ccd_tg_pkg.sv
// Shared types and the vertical gate stepping pattern for the CCD timing generator.
package ccd_tg_pkg;

    typedef enum logic {
        RD_PROG = 1'b0,
        RD_FAST = 1'b1
    } rd_mode_e;

    // Gate levels {g1, g2, g3} for each step of the row-shift rotation; step 0 is rest.
    function automatic logic [2:0] vgate_pat(input logic [2:0] step);
        case (step)
            3'd0:    return 3'b110;
            3'd1:    return 3'b010;
            3'd2:    return 3'b011;
            3'd3:    return 3'b001;
            3'd4:    return 3'b101;
            default: return 3'b100;
        endcase
    endfunction

endpackage

// File: rtl/ccd_tg_timebase.sv
// Tick, pixel and line counters plus the frame-boundary shadow of mode and shutter.
// Assumes PIX_TICKS >= 2 and that the line width fits both frame lengths.
module ccd_tg_timebase
    import ccd_tg_pkg::*;
#(
    parameter int PIX_TICKS  = 4,
    parameter int LINE_PIX   = 1270,
    parameter int V_ROWS     = 788,
    parameter int V_TOT_PROG = 792,
    parameter int V_TOT_FAST = 525,
    parameter int LINE_W     = 10,
    parameter int SW         = 2,
    parameter int HW         = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_in,
    input  logic              shen_in,
    input  logic [LINE_W-1:0] shline_in,
    output logic [SW-1:0]     s_q,
    output logic [HW-1:0]     h_q,
    output logic [LINE_W-1:0] line_q,
    output rd_mode_e          mode_q,
    output logic              shen_q,
    output logic [LINE_W-1:0] shline_q,
    output logic              xfer_line
);

    localparam int FAST_ROWS = (V_ROWS + 2) / 3;
    localparam logic [SW-1:0]     S_LAST  = SW'(PIX_TICKS - 1);
    localparam logic [HW-1:0]     H_LAST  = HW'(LINE_PIX - 1);
    localparam logic [LINE_W-1:0] LP_LAST = LINE_W'(V_TOT_PROG - 1);
    localparam logic [LINE_W-1:0] LF_LAST = LINE_W'(V_TOT_FAST - 1);
    localparam logic [LINE_W-1:0] XP_LAST = LINE_W'(V_ROWS);
    localparam logic [LINE_W-1:0] XF_LAST = LINE_W'(FAST_ROWS);

    logic [LINE_W-1:0] frame_last;

    // Last line index of the current frame for the latched mode.
    always_comb frame_last = (mode_q == RD_FAST) ? LF_LAST : LP_LAST;

    // Advance tick, pixel and line; reload the shadow settings at the frame wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            h_q      <= '0;
            line_q   <= '0;
            mode_q   <= rd_mode_e'(mode_in);
            shen_q   <= shen_in;
            shline_q <= shline_in;
        end else if (s_q != S_LAST) begin
            s_q <= s_q + 1'b1;
        end else begin
            s_q <= '0;
            if (h_q != H_LAST) begin
                h_q <= h_q + 1'b1;
            end else begin
                h_q <= '0;
                if (line_q != frame_last) begin
                    line_q <= line_q + 1'b1;
                end else begin
                    line_q   <= '0;
                    mode_q   <= rd_mode_e'(mode_in);
                    shen_q   <= shen_in;
                    shline_q <= shline_in;
                end
            end
        end
    end

    // Flag lines that carry a row through the horizontal register.
    always_comb xfer_line = (line_q != '0) &&
                            (line_q <= ((mode_q == RD_FAST) ? XF_LAST : XP_LAST));

    // R10
    mode_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mode_q) || !$stable(shline_q) || !$stable(shen_q))
            |-> (line_q == '0 && h_q == '0 && s_q == '0));

endmodule

// File: rtl/ccd_tg_hgen.sv
// Horizontal drive: line sync, transfer window, shift clocks, reset gate and sample strobes.
// Assumes the counters come from ccd_tg_timebase and H_BLANK > HD_W.
module ccd_tg_hgen #(
    parameter int PIX_TICKS  = 4,
    parameter int H_BLANK    = 164,
    parameter int H_DUMMY    = 29,
    parameter int H_OB_FRONT = 3,
    parameter int H_EFF      = 1034,
    parameter int HD_W       = 45,
    parameter int RG_POS     = 0,
    parameter int SHP_POS    = 1,
    parameter int SHD_POS    = 3,
    parameter int SW         = 2,
    parameter int HW         = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] s_q,
    input  logic [HW-1:0] h_q,
    input  logic          xfer_line,
    output logic          hsync,
    output logic          xfer_blank,
    output logic          pix_active,
    output logic          hclk1,
    output logic          hclk2,
    output logic          rst_gate,
    output logic          samp_ref,
    output logic          samp_data
);

    localparam logic [HW-1:0] HD_END = HW'(HD_W);
    localparam logic [HW-1:0] WIN0   = HW'(H_BLANK);
    localparam logic [HW-1:0] EFF0   = HW'(H_BLANK + H_DUMMY + H_OB_FRONT);
    localparam logic [HW-1:0] EFF1   = HW'(H_BLANK + H_DUMMY + H_OB_FRONT + H_EFF);
    localparam logic [SW-1:0] HALF   = SW'(PIX_TICKS / 2);
    localparam logic [SW-1:0] RG_S   = SW'(RG_POS);
    localparam logic [SW-1:0] SHP_S  = SW'(SHP_POS);
    localparam logic [SW-1:0] SHD_S  = SW'(SHD_POS);

    logic in_win;
    logic first_half;

    // Transfer window and pixel half-phase.
    always_comb begin
        in_win     = xfer_line && (h_q >= WIN0);
        first_half = (s_q < HALF);
    end

    // Sync, blanking and effective-pixel flag.
    always_comb begin
        hsync      = (h_q < HD_END);
        xfer_blank = !in_win;
        pix_active = in_win && (h_q >= EFF0) && (h_q < EFF1);
    end

    // Two-phase shift clocks, parked during blanking.
    always_comb begin
        hclk1 = in_win ? first_half  : 1'b1;
        hclk2 = in_win ? !first_half : 1'b0;
    end

    // One-tick per-pixel reset and sample strobes.
    always_comb begin
        rst_gate  = in_win && (s_q == RG_S);
        samp_ref  = in_win && (s_q == SHP_S);
        samp_data = in_win && (s_q == SHD_S);
    end

    // R4
    valid_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_active |-> (!xfer_blank && !hsync));

    // R5
    h_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_blank && $past(xfer_blank)) |-> ($stable(hclk1) && $stable(hclk2)));

    // R6
    rg_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_gate |=> !rst_gate);

endmodule

// File: rtl/ccd_tg_vgen.sv
// Vertical drive: row-shift gate rotation, readout pulses and substrate drain pulses.
// Assumes VS_START >= 1 and that the shift window and drain pulse end inside H_BLANK.
module ccd_tg_vgen
    import ccd_tg_pkg::*;
#(
    parameter int PIX_TICKS = 4,
    parameter int LINE_PIX  = 1270,
    parameter int VS_START  = 4,
    parameter int VS_STEP   = 8,
    parameter int RD_POS    = 848,
    parameter int RD_W      = 51,
    parameter int RD_SKEW   = 2,
    parameter int SUB_POS   = 150,
    parameter int SUB_W     = 10,
    parameter int LINE_W    = 10,
    parameter int SW        = 2,
    parameter int HW        = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SW-1:0]     s_q,
    input  logic [HW-1:0]     h_q,
    input  logic [LINE_W-1:0] line_q,
    input  rd_mode_e          mode_q,
    input  logic              xfer_line,
    input  logic              shen_q,
    input  logic [LINE_W-1:0] shline_q,
    output logic              vg1,
    output logic              vg2a,
    output logic              vg2b,
    output logic              vg3,
    output logic              rd_pulse_a,
    output logic              rd_pulse_b,
    output logic              sub_drain
);

    localparam int DW = (VS_STEP > 1) ? $clog2(VS_STEP) : 1;
    localparam logic [SW-1:0] S_LAST = SW'(PIX_TICKS - 1);
    localparam logic [HW-1:0] H_LAST = HW'(LINE_PIX - 1);
    localparam logic [HW-1:0] VS0    = HW'(VS_START);
    localparam logic [HW-1:0] VS_EP  = HW'(VS_START + 6 * VS_STEP);
    localparam logic [HW-1:0] VS_EF  = HW'(VS_START + 18 * VS_STEP);
    localparam logic [DW-1:0] DW_LST = DW'(VS_STEP - 1);
    localparam logic [HW-1:0] RA0    = HW'(RD_POS);
    localparam logic [HW-1:0] RA1    = HW'(RD_POS + RD_W);
    localparam logic [HW-1:0] RB0    = HW'(RD_POS + RD_SKEW);
    localparam logic [HW-1:0] RB1    = HW'(RD_POS + RD_SKEW + RD_W);
    localparam logic [HW-1:0] SB0    = HW'(SUB_POS);
    localparam logic [HW-1:0] SB1    = HW'(SUB_POS + SUB_W);

    logic [2:0]    step_q;
    logic [DW-1:0] dwell_q;
    logic [HW-1:0] h_nx;
    logic          nx_in_win;
    logic [2:0]    gates;
    logic          rd_line;

    // Pixel index of the next pixel and whether it lies in the shift window.
    always_comb begin
        h_nx      = (h_q == H_LAST) ? '0 : h_q + 1'b1;
        nx_in_win = xfer_line && (h_nx >= VS0) &&
                    (h_nx < ((mode_q == RD_FAST) ? VS_EF : VS_EP));
    end

    // Step the gate rotation at each pixel boundary inside the shift window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q  <= '0;
            dwell_q <= '0;
        end else if (s_q == S_LAST) begin
            if (!nx_in_win) begin
                step_q  <= '0;
                dwell_q <= '0;
            end else if (h_nx == VS0 || dwell_q == DW_LST) begin
                step_q  <= (step_q == 3'd5) ? 3'd0 : step_q + 3'd1;
                dwell_q <= '0;
            end else begin
                dwell_q <= dwell_q + 1'b1;
            end
        end
    end

    // Map the rotation step onto the gate outputs.
    always_comb begin
        gates = vgate_pat(step_q);
        vg1   = gates[2];
        vg2a  = gates[1];
        vg2b  = gates[1];
        vg3   = gates[0];
    end

    // Readout pulses on the frame's first line.
    always_comb begin
        rd_line    = (line_q == '0);
        rd_pulse_a = rd_line && (h_q >= RA0) && (h_q < RA1);
        rd_pulse_b = rd_line && (mode_q == RD_PROG) && (h_q >= RB0) && (h_q < RB1);
    end

    // Substrate drain on lines before the programmed exposure start.
    always_comb sub_drain = shen_q && (line_q != '0) && (line_q < shline_q) &&
                            (h_q >= SB0) && (h_q < SB1);

    // R8
    sg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pulse_a || rd_pulse_b) |-> (vg2a && vg2b));

    // R7
    gate_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({vg1, vg2a, vg3} ^ $past({vg1, vg2a, vg3})) <= 1);

endmodule

// File: rtl/ccd_tg.sv
// Top of the CCD drive timing generator: counters, horizontal and vertical drive.
// Assumes parameters place vertical shift and drain pulse inside horizontal blanking.
module ccd_tg
    import ccd_tg_pkg::*;
#(
    parameter int PIX_TICKS  = 4,
    parameter int H_BLANK    = 164,
    parameter int H_DUMMY    = 29,
    parameter int H_OB_FRONT = 3,
    parameter int H_EFF      = 1034,
    parameter int H_OB_REAR  = 40,
    parameter int HD_W       = 45,
    parameter int RG_POS     = 0,
    parameter int SHP_POS    = 1,
    parameter int SHD_POS    = 3,
    parameter int VS_START   = 4,
    parameter int VS_STEP    = 8,
    parameter int RD_POS     = 848,
    parameter int RD_W       = 51,
    parameter int RD_SKEW    = 2,
    parameter int SUB_POS    = 150,
    parameter int SUB_W      = 10,
    parameter int V_ROWS     = 788,
    parameter int V_TOT_PROG = 792,
    parameter int V_TOT_FAST = 525,
    parameter int LINE_W     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_mode,
    input  logic              shutter_en,
    input  logic [LINE_W-1:0] shutter_line,
    output logic              hsync,
    output logic              vsync,
    output logic              xfer_blank,
    output logic              pix_active,
    output logic              hclk1,
    output logic              hclk2,
    output logic              rst_gate,
    output logic              samp_ref,
    output logic              samp_data,
    output logic              vg1,
    output logic              vg2a,
    output logic              vg2b,
    output logic              vg3,
    output logic              rd_pulse_a,
    output logic              rd_pulse_b,
    output logic              sub_drain
);

    localparam int LINE_PIX = H_BLANK + H_DUMMY + H_OB_FRONT + H_EFF + H_OB_REAR;
    localparam int SW       = (PIX_TICKS > 1) ? $clog2(PIX_TICKS) : 1;
    localparam int HW       = $clog2(LINE_PIX);

    logic [SW-1:0]     s_q;
    logic [HW-1:0]     h_q;
    logic [LINE_W-1:0] line_q;
    rd_mode_e          mode_q;
    logic              shen_q;
    logic [LINE_W-1:0] shline_q;
    logic              xfer_line;

    ccd_tg_timebase #(
        .PIX_TICKS(PIX_TICKS), .LINE_PIX(LINE_PIX), .V_ROWS(V_ROWS),
        .V_TOT_PROG(V_TOT_PROG), .V_TOT_FAST(V_TOT_FAST), .LINE_W(LINE_W),
        .SW(SW), .HW(HW)
    ) u_tb (
        .clk(clk), .rst_n(rst_n), .mode_in(fast_mode), .shen_in(shutter_en),
        .shline_in(shutter_line), .s_q(s_q), .h_q(h_q), .line_q(line_q),
        .mode_q(mode_q), .shen_q(shen_q), .shline_q(shline_q), .xfer_line(xfer_line)
    );

    ccd_tg_hgen #(
        .PIX_TICKS(PIX_TICKS), .H_BLANK(H_BLANK), .H_DUMMY(H_DUMMY),
        .H_OB_FRONT(H_OB_FRONT), .H_EFF(H_EFF), .HD_W(HD_W), .RG_POS(RG_POS),
        .SHP_POS(SHP_POS), .SHD_POS(SHD_POS), .SW(SW), .HW(HW)
    ) u_hg (
        .clk(clk), .rst_n(rst_n), .s_q(s_q), .h_q(h_q), .xfer_line(xfer_line),
        .hsync(hsync), .xfer_blank(xfer_blank), .pix_active(pix_active),
        .hclk1(hclk1), .hclk2(hclk2), .rst_gate(rst_gate),
        .samp_ref(samp_ref), .samp_data(samp_data)
    );

    ccd_tg_vgen #(
        .PIX_TICKS(PIX_TICKS), .LINE_PIX(LINE_PIX), .VS_START(VS_START),
        .VS_STEP(VS_STEP), .RD_POS(RD_POS), .RD_W(RD_W), .RD_SKEW(RD_SKEW),
        .SUB_POS(SUB_POS), .SUB_W(SUB_W), .LINE_W(LINE_W), .SW(SW), .HW(HW)
    ) u_vg (
        .clk(clk), .rst_n(rst_n), .s_q(s_q), .h_q(h_q), .line_q(line_q),
        .mode_q(mode_q), .xfer_line(xfer_line), .shen_q(shen_q), .shline_q(shline_q),
        .vg1(vg1), .vg2a(vg2a), .vg2b(vg2b), .vg3(vg3),
        .rd_pulse_a(rd_pulse_a), .rd_pulse_b(rd_pulse_b), .sub_drain(sub_drain)
    );

    // Frame sync spans the whole readout line.
    always_comb vsync = (line_q == '0);

    // R9
    drain_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sub_drain |-> (xfer_blank && !rd_pulse_a));

endmodule

// File: tb/ccd_tg_bench.sv
// Self-checking bench: behavioural reference model compared on every clock.
module ccd_tg_bench;

    localparam int PT = 4, HB = 28, HDU = 2, HOF = 1, HEF = 6, HOR = 2, HDW = 4;
    localparam int RGP = 0, SHP = 1, SHD = 3, VSS = 2, VST = 1;
    localparam int RDP = 10, RDW = 5, RDS = 2, SBP = 22, SBW = 3;
    localparam int VR = 9, VTP = 12, VTF = 6, LW = 10;
    localparam int LPX = HB + HDU + HOF + HEF + HOR;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fast_mode = 1'b0;
    logic shutter_en = 1'b0;
    logic [LW-1:0] shutter_line = '0;
    logic hsync, vsync, xfer_blank, pix_active, hclk1, hclk2, rst_gate, samp_ref, samp_data;
    logic vg1, vg2a, vg2b, vg3, rd_pulse_a, rd_pulse_b, sub_drain;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ccd_tg #(
        .PIX_TICKS(PT), .H_BLANK(HB), .H_DUMMY(HDU), .H_OB_FRONT(HOF), .H_EFF(HEF),
        .H_OB_REAR(HOR), .HD_W(HDW), .RG_POS(RGP), .SHP_POS(SHP), .SHD_POS(SHD),
        .VS_START(VSS), .VS_STEP(VST), .RD_POS(RDP), .RD_W(RDW), .RD_SKEW(RDS),
        .SUB_POS(SBP), .SUB_W(SBW), .V_ROWS(VR), .V_TOT_PROG(VTP), .V_TOT_FAST(VTF),
        .LINE_W(LW)
    ) u_ccd_tg (
        .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .shutter_en(shutter_en),
        .shutter_line(shutter_line), .hsync(hsync), .vsync(vsync), .xfer_blank(xfer_blank),
        .pix_active(pix_active), .hclk1(hclk1), .hclk2(hclk2), .rst_gate(rst_gate),
        .samp_ref(samp_ref), .samp_data(samp_data), .vg1(vg1), .vg2a(vg2a), .vg2b(vg2b),
        .vg3(vg3), .rd_pulse_a(rd_pulse_a), .rd_pulse_b(rd_pulse_b), .sub_drain(sub_drain)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model state: tick, pixel, line and the settings in force.
    int ms = 0, mh = 0, ml = 0, mmode = 0, men = 0, mline = 0;
    bit mvalid = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; mh = 0; ml = 0;
            mmode = fast_mode; men = shutter_en; mline = int'(shutter_line);
            mvalid = 1'b1;
        end else begin
            ms = ms + 1;
            if (ms == PT) begin
                ms = 0; mh = mh + 1;
                if (mh == LPX) begin
                    mh = 0; ml = ml + 1;
                    if (ml == (mmode ? VTF : VTP)) begin
                        ml = 0;
                        mmode = fast_mode; men = shutter_en; mline = int'(shutter_line);
                    end
                end
            end
        end
    end

    // Aggregate counters per frame and per line.
    int hd_cnt = 0, sga_cnt = 0, sgb_cnt = 0, act_cnt = 0, fm = 0;
    bit hd_p = 1'b1, vd_p = 1'b1, sga_p = 1'b0, sgb_p = 1'b0, line_xf = 1'b0;

    always @(negedge clk) begin : cmp
        int nx, st, ns, k;
        bit xl, win;
        logic [2:0] g;
        if (mvalid) begin
            nx  = mmode ? (VR + 2) / 3 : VR;
            xl  = (ml >= 1) && (ml <= nx);
            win = xl && (mh >= HB);
            chk("R1", "hsync", hsync, mh < HDW);
            chk("R2", "vsync", vsync, ml == 0);
            chk("R3", "xfer_blank", xfer_blank, !win);
            chk("R4", "pix_active", pix_active,
                win && mh >= HB + HDU + HOF && mh < HB + HDU + HOF + HEF);
            chk("R5", "hclk1", hclk1, win ? (ms < PT / 2) : 1);
            chk("R5", "hclk2", hclk2, win ? !(ms < PT / 2) : 0);
            chk("R6", "rst_gate", rst_gate, win && ms == RGP);
            chk("R6", "samp_ref", samp_ref, win && ms == SHP);
            chk("R6", "samp_data", samp_data, win && ms == SHD);
            ns = mmode ? 3 : 1;
            st = 0;
            if (xl && mh >= VSS && mh < VSS + ns * 6 * VST) begin
                k  = (mh - VSS) / VST;
                st = ((k % 6) + 1) % 6;
            end
            case (st)
                0: g = 3'b110;
                1: g = 3'b010;
                2: g = 3'b011;
                3: g = 3'b001;
                4: g = 3'b101;
                default: g = 3'b100;
            endcase
            chk("R7", "vg1", vg1, g[2]);
            chk("R7", "vg2a", vg2a, g[1]);
            chk("R7", "vg2b", vg2b, g[1]);
            chk("R7", "vg3", vg3, g[0]);
            chk("R8", "rd_pulse_a", rd_pulse_a, ml == 0 && mh >= RDP && mh < RDP + RDW);
            chk("R8", "rd_pulse_b", rd_pulse_b,
                !mmode && ml == 0 && mh >= RDP + RDS && mh < RDP + RDS + RDW);
            chk("R9", "sub_drain", sub_drain,
                men && ml >= 1 && ml < mline && mh >= SBP && mh < SBP + SBW);
        end
        if (rst_n && mvalid) begin
            if (hsync && !hd_p) begin
                hd_cnt++;
                // R4 active pixel count per line
                chk("R4", "active clocks per line", act_cnt, line_xf ? HEF * PT : 0);
                act_cnt = 0;
                line_xf = 1'b0;
            end
            if (vsync && !vd_p) begin
                // R2 R10 lines per frame follow the mode latched at the frame start
                chk("R2 R10", "lines per frame", hd_cnt, fm ? VTF : VTP);
                chk("R8", "rd_pulse_a per frame", sga_cnt, 1);
                chk("R8", "rd_pulse_b per frame", sgb_cnt, fm ? 0 : 1);
                hd_cnt = 0; sga_cnt = 0; sgb_cnt = 0;
                fm = mmode;
            end
            if (rd_pulse_a && !sga_p) sga_cnt++;
            if (rd_pulse_b && !sgb_p) sgb_cnt++;
            if (pix_active) act_cnt++;
            if (!xfer_blank) line_xf = 1'b1;
        end
        hd_p = hsync; vd_p = vsync; sga_p = rd_pulse_a; sgb_p = rd_pulse_b;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // Reset state: line 0, pixel 0
        chk("R2", "reset vsync", vsync, 1);
        chk("R1", "reset hsync", hsync, 1);
        chk("R3", "reset xfer_blank", xfer_blank, 1);
        chk("R9", "reset sub_drain", sub_drain, 0);
        rst_n = 1'b1;
        fm = 0;
        repeat (2500) @(negedge clk);
        // R10: shutter set mid-frame, effective only from the next frame
        shutter_en = 1'b1; shutter_line = 10'd5;
        repeat (3000) @(negedge clk);
        // R10: fast mode requested mid-frame
        fast_mode = 1'b1;
        repeat (4000) @(negedge clk);
        shutter_line = 10'd2;
        repeat (2000) @(negedge clk);
        shutter_line = 10'd0;
        repeat (2000) @(negedge clk);
        fast_mode = 1'b0; shutter_line = 10'd12;
        repeat (4500) @(negedge clk);
        shutter_en = 1'b0;
        repeat (2500) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog: actual 0 expected 1");
            summary();
            $finish;
        end
    end

endmodule